// File: doc/BRIEF.md
# Multi-Port Register Bank with Priority Writes

A small bank of registers that several read ports and several write ports can all use in the same clock cycle, with no arbiter and no handshake. Each read port has its own address and a multiplexer over the whole bank, so every reader can fetch any register in the cycle it asks. Each write port has its own address decoder and enable. Writes to different registers all land at the same clock edge.

When two or more enabled writers aim at the same register in one cycle, a fixed priority chooses the single write that lands. The lowest-numbered port wins. A losing writer gets no retry. Instead, the bank raises that writer's one-cycle `wr_dropped` flag, and the surrounding logic decides what to do about it. The register count, data width and number of each kind of port are parameters. The read multiplexer style is also chosen by a parameter. The block suits small banks, because the decoders and multiplexers grow with ports times registers.

Top module: `multiport_regbank`

## Requirements
- R1: While `rst_n` is low and after its release, every register reads as zero and every bit of `wr_dropped` is 0.
- R2: Each read port returns, combinationally and independently of the other read ports, the value held by the register its address selects.
- R3: An enabled write to an in-range address updates that register at the next rising clock edge. A read of the same register in that cycle returns the value held before the edge.
- R4: Enabled writes to distinct registers all take effect at the same clock edge.
- R5: When several enabled writers target one register in a cycle, only the data of the lowest-numbered of them is stored. Write port 0 therefore never loses.
- R6: `wr_dropped[w]` is 1 for exactly the one cycle after an edge at which port w's enabled, in-range write lost to a lower-numbered port. It is 0 in every other cycle.
- R7: A write port whose `wr_en` bit is 0 changes no register and takes no part in collisions, whatever its address and data.
- R8: Addresses at or above `NUM_REGS` are out of range. A write to one changes nothing and raises no `wr_dropped`. A read of one returns zero.
- R9: A register that no enabled, winning write targets keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | NUM_WR | Write enable, one bit per write port |
| wr_addr | input | NUM_WR*ADDR_W | Write addresses, port w in bits [w*ADDR_W +: ADDR_W] |
| wr_data | input | NUM_WR*DATA_W | Write data, port w in bits [w*DATA_W +: DATA_W] |
| wr_dropped | output | NUM_WR | Registered flag: the port's write of the previous cycle lost a collision |
| rd_addr | input | NUM_RD*ADDR_W | Read addresses, port r in bits [r*ADDR_W +: ADDR_W] |
| rd_data | output | NUM_RD*DATA_W | Read data, port r in bits [r*DATA_W +: DATA_W] |

## Verification
Read data depends combinationally on the read address and the stored registers. It is sampled 1 ns after the bench drives new inputs, which happens on the falling edge, before the next rising edge. That read therefore reflects all writes from earlier edges and none from the current cycle.

Stored write data and the `wr_dropped` flags both follow one rising edge after the stimulus. The bench compares the flags at the next falling edge against the expected values it computed when it issued the writes. It compares register contents through the read ports in later cycles.

Random stimulus is weighted towards a few addresses, including out-of-range ones, so that collisions among two or three writers happen often. Directed steps cover the all-ports collision, a collision with port 0 disabled, and out-of-range writes.

// File: rtl/mprb_pkg.sv
package mprb_pkg;

   // Upper bound on write ports handled by the priority function below.
   localparam int unsigned MPRB_MAX_PORTS = 32;

   // Read multiplexer implementation variants.
   typedef enum logic {
      RDMUX_INDEXED = 1'b0,   // variable part-select with range guard
      RDMUX_ANDOR   = 1'b1    // decoded one-hot AND-OR tree
   } rdmux_kind_e;

   // Isolate the least significant set bit (lowest port number wins).
   function automatic logic [MPRB_MAX_PORTS-1:0] lowest_set
      (input logic [MPRB_MAX_PORTS-1:0] vec);
      return vec & (~vec + {{(MPRB_MAX_PORTS-1){1'b0}}, 1'b1});
   endfunction

endpackage

// File: rtl/mprb_wr_decode.sv
module mprb_wr_decode #(
   parameter int unsigned NUM_REGS = 6,
   parameter int unsigned ADDR_W   = 3
) (
   input  logic                en,
   input  logic [ADDR_W-1:0]   addr,
   output logic [NUM_REGS-1:0] hit
);

   // One select line per register; out-of-range addresses select none.
   always_comb begin
      for (int r = 0; r < NUM_REGS; r++) begin
         hit[r] = en && (addr == ADDR_W'(r));
      end
   end

endmodule

// File: rtl/mprb_wr_arbiter.sv
module mprb_wr_arbiter
   import mprb_pkg::*;
#(
   parameter int unsigned NUM_WR = 3,
   parameter int unsigned DATA_W = 16
) (
   input  logic [NUM_WR-1:0]        req,
   input  logic [NUM_WR*DATA_W-1:0] data_in,
   output logic [NUM_WR-1:0]        grant,
   output logic                     we,
   output logic [DATA_W-1:0]        data_out
);

   logic [MPRB_MAX_PORTS-1:0] req_wide;
   logic [MPRB_MAX_PORTS-1:0] grant_wide;

   always_comb begin
      req_wide              = '0;
      req_wide[NUM_WR-1:0]  = req;
      grant_wide            = lowest_set(req_wide);
      grant                 = grant_wide[NUM_WR-1:0];
      we                    = |req;
   end

   // Data select driven by the one-hot grant.
   always_comb begin
      data_out = '0;
      for (int w = 0; w < NUM_WR; w++) begin
         data_out = data_out | (data_in[w*DATA_W +: DATA_W] & {DATA_W{grant[w]}});
      end
   end

endmodule

// File: rtl/mprb_rd_mux.sv
module mprb_rd_mux
   import mprb_pkg::*;
#(
   parameter int unsigned NUM_REGS = 6,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned ADDR_W   = 3,
   parameter rdmux_kind_e KIND     = RDMUX_ANDOR
) (
   input  logic [NUM_REGS*DATA_W-1:0] regs,
   input  logic [ADDR_W-1:0]          addr,
   output logic [DATA_W-1:0]          data
);

   generate
      if (KIND == RDMUX_INDEXED) begin : g_indexed
         always_comb begin
            if (int'(addr) < int'(NUM_REGS)) begin
               data = regs[int'(addr)*DATA_W +: DATA_W];
            end else begin
               data = '0;
            end
         end
      end else begin : g_andor
         logic [NUM_REGS-1:0] sel;
         always_comb begin
            for (int r = 0; r < NUM_REGS; r++) begin
               sel[r] = (addr == ADDR_W'(r));
            end
         end
         always_comb begin
            data = '0;
            for (int r = 0; r < NUM_REGS; r++) begin
               data = data | (regs[r*DATA_W +: DATA_W] & {DATA_W{sel[r]}});
            end
         end
      end
   endgenerate

endmodule

// File: rtl/multiport_regbank.sv
module multiport_regbank
   import mprb_pkg::*;
#(
   parameter int unsigned NUM_REGS = 6,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned NUM_WR   = 3,
   parameter int unsigned NUM_RD   = 2,
   parameter int unsigned ADDR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
   parameter rdmux_kind_e RD_KIND  = RDMUX_ANDOR
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_WR-1:0]        wr_en,
   input  logic [NUM_WR*ADDR_W-1:0] wr_addr,
   input  logic [NUM_WR*DATA_W-1:0] wr_data,
   output logic [NUM_WR-1:0]        wr_dropped,
   input  logic [NUM_RD*ADDR_W-1:0] rd_addr,
   output logic [NUM_RD*DATA_W-1:0] rd_data
);

   localparam int unsigned MIN_ADDR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
   localparam int unsigned BANK_BITS  = NUM_REGS * DATA_W;

   // Elaboration-time parameter checks.
   generate
      if (NUM_REGS < 1)              begin : g_bad_regs  $error("NUM_REGS must be at least 1"); end
      if (DATA_W < 1)                begin : g_bad_width $error("DATA_W must be at least 1"); end
      if (NUM_WR < 1 || NUM_WR > MPRB_MAX_PORTS) begin : g_bad_wr $error("NUM_WR out of range"); end
      if (NUM_RD < 1)                begin : g_bad_rd    $error("NUM_RD must be at least 1"); end
      if (ADDR_W < MIN_ADDR_W)       begin : g_bad_addr  $error("ADDR_W too narrow for NUM_REGS"); end
   endgenerate

   logic [NUM_REGS-1:0] hit_by_wr   [NUM_WR];
   logic [NUM_WR-1:0]   req_by_reg  [NUM_REGS];
   logic [NUM_WR-1:0]   grant_by_reg[NUM_REGS];
   logic [NUM_REGS-1:0] we_by_reg;
   logic [DATA_W-1:0]   wdata_by_reg[NUM_REGS];
   logic [BANK_BITS-1:0] bank_q;
   logic [NUM_WR-1:0]   lost;

   // Per-port address decoders.
   generate
      for (genvar w = 0; w < NUM_WR; w++) begin : g_wdec
         mprb_wr_decode #(
            .NUM_REGS (NUM_REGS),
            .ADDR_W   (ADDR_W)
         ) dec_i (
            .en   (wr_en[w]),
            .addr (wr_addr[w*ADDR_W +: ADDR_W]),
            .hit  (hit_by_wr[w])
         );
      end
   endgenerate

   // Transpose: per register, which ports request it.
   always_comb begin
      for (int r = 0; r < NUM_REGS; r++) begin
         for (int w = 0; w < NUM_WR; w++) begin
            req_by_reg[r][w] = hit_by_wr[w][r];
         end
      end
   end

   // Per-register priority resolution and storage.
   generate
      for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
         mprb_wr_arbiter #(
            .NUM_WR (NUM_WR),
            .DATA_W (DATA_W)
         ) arb_i (
            .req      (req_by_reg[r]),
            .data_in  (wr_data),
            .grant    (grant_by_reg[r]),
            .we       (we_by_reg[r]),
            .data_out (wdata_by_reg[r])
         );

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               bank_q[r*DATA_W +: DATA_W] <= '0;
            end else if (we_by_reg[r]) begin
               bank_q[r*DATA_W +: DATA_W] <= wdata_by_reg[r];
            end
         end
      end
   endgenerate

   // A port lost when it requested a register but was not granted it.
   always_comb begin
      lost = '0;
      for (int w = 0; w < NUM_WR; w++) begin
         for (int r = 0; r < NUM_REGS; r++) begin
            lost[w] = lost[w] | (req_by_reg[r][w] & ~grant_by_reg[r][w]);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_dropped <= '0;
      end else begin
         wr_dropped <= lost;
      end
   end

   // Independent read multiplexers.
   generate
      for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
         mprb_rd_mux #(
            .NUM_REGS (NUM_REGS),
            .DATA_W   (DATA_W),
            .ADDR_W   (ADDR_W),
            .KIND     (RD_KIND)
         ) mux_i (
            .regs (bank_q),
            .addr (rd_addr[p*ADDR_W +: ADDR_W]),
            .data (rd_data[p*DATA_W +: DATA_W])
         );
      end
   endgenerate

endmodule

// File: rtl/mprb_checker.sv
module mprb_checker #(
   parameter int unsigned NUM_REGS = 6,
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned NUM_WR   = 3,
   parameter int unsigned NUM_RD   = 2,
   parameter int unsigned ADDR_W   = 3
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [NUM_WR-1:0]        wr_en,
   input logic [NUM_WR*ADDR_W-1:0] wr_addr,
   input logic [NUM_WR-1:0]        wr_dropped,
   input logic [NUM_RD*ADDR_W-1:0] rd_addr,
   input logic [NUM_RD*DATA_W-1:0] rd_data
);

   // R1
   drop_clear_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (wr_dropped == '0));

   // R5
   port0_never_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_dropped[0]);

   // R9
   idle_read_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_en == '0) && $stable(rd_addr)) |-> $stable(rd_data));

   generate
      for (genvar w = 0; w < NUM_WR; w++) begin : g_wchk
         // R6
         drop_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_dropped[w] |-> $past(wr_en[w]));

         if (w > 0) begin : g_lose
            // R6
            loses_to_port0_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (wr_en[0] && wr_en[w]
                && (wr_addr[0 +: ADDR_W] == wr_addr[w*ADDR_W +: ADDR_W])
                && (int'(wr_addr[0 +: ADDR_W]) < int'(NUM_REGS)))
               |=> wr_dropped[w]);
         end
      end

      for (genvar p = 0; p < NUM_RD; p++) begin : g_rchk
         // R8
         out_of_range_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(rd_addr[p*ADDR_W +: ADDR_W]) >= int'(NUM_REGS))
            |-> (rd_data[p*DATA_W +: DATA_W] == '0));
      end
   endgenerate

endmodule

bind multiport_regbank mprb_checker #(
   .NUM_REGS (NUM_REGS),
   .DATA_W   (DATA_W),
   .NUM_WR   (NUM_WR),
   .NUM_RD   (NUM_RD),
   .ADDR_W   (ADDR_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_dropped (wr_dropped),
   .rd_addr    (rd_addr),
   .rd_data    (rd_data)
);

// File: tb/multiport_regbank_tb_top.sv
`timescale 1ns/1ps
module multiport_regbank_tb_top;

   localparam int NR  = 6;
   localparam int DW  = 16;
   localparam int NW  = 3;
   localparam int NRD = 2;
   localparam int AW  = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic [NW-1:0]     wr_en = '0;
   logic [NW*AW-1:0]  wr_addr = '0;
   logic [NW*DW-1:0]  wr_data = '0;
   logic [NW-1:0]     wr_dropped;
   logic [NRD*AW-1:0] rd_addr = '0;
   logic [NRD*DW-1:0] rd_data;

   multiport_regbank #(
      .NUM_REGS (NR), .DATA_W (DW), .NUM_WR (NW), .NUM_RD (NRD), .ADDR_W (AW)
   ) dut_i (
      .clk (clk), .rst_n (rst_n),
      .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
      .wr_dropped (wr_dropped),
      .rd_addr (rd_addr), .rd_data (rd_data)
   );

   logic [DW-1:0] model [NR];
   logic [NW-1:0] exp_drop = '0;
   logic          st_en   [NW];
   logic [AW-1:0] st_addr [NW];
   logic [DW-1:0] st_data [NW];
   logic [AW-1:0] st_raddr[NRD];
   int n_cmp = 0;
   int n_bad = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
      return (int'(a) < NR) ? model[int'(a)] : '0;
   endfunction

   // One cycle: check previous flags, drive, check reads, update model.
   task automatic step(input string rtag);
      logic [NW-1:0] nd;
      @(negedge clk);
      chk("R6 dropped", 32'(wr_dropped), 32'(exp_drop));
      for (int w = 0; w < NW; w++) begin
         wr_en[w] = st_en[w];
         wr_addr[w*AW +: AW] = st_addr[w];
         wr_data[w*DW +: DW] = st_data[w];
      end
      for (int p = 0; p < NRD; p++) rd_addr[p*AW +: AW] = st_raddr[p];
      #1;
      for (int p = 0; p < NRD; p++)
         chk(rtag, 32'(rd_data[p*DW +: DW]), 32'(exp_read(st_raddr[p])));
      nd = '0;
      for (int r = 0; r < NR; r++) begin
         int win;
         win = -1;
         for (int w = 0; w < NW; w++) begin
            if (st_en[w] && int'(st_addr[w]) == r) begin
               if (win < 0) win = w;
               else nd[w] = 1'b1;
            end
         end
         if (win >= 0) model[r] = st_data[win];
      end
      exp_drop = nd;
   endtask

   task automatic idle_writes();
      for (int w = 0; w < NW; w++) begin
         st_en[w] = 1'b0; st_addr[w] = '0; st_data[w] = '0;
      end
   endtask

   initial begin
      #(4 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      for (int r = 0; r < NR; r++) model[r] = '0;
      idle_writes();
      for (int p = 0; p < NRD; p++) st_raddr[p] = '0;

      // R1: reset state through the read ports.
      repeat (3) @(posedge clk);
      @(negedge clk);
      wr_en = '1;   // writes during reset must not land
      for (int r = 0; r < NR; r++) begin
         rd_addr[0 +: AW] = AW'(r);
         #0.1;
         chk("R1 reset read", 32'(rd_data[0 +: DW]), 32'h0);
      end
      @(posedge clk);
      @(negedge clk);
      wr_en = '0;
      chk("R1 reset dropped", 32'(wr_dropped), 32'h0);
      rst_n = 1'b1;
      for (int r = 0; r < NR; r++) begin
         st_raddr[0] = AW'(r); st_raddr[1] = AW'(NR - 1 - r);
         step("R1 post-reset read");
      end

      // R4: three writers, distinct registers.
      st_en[0] = 1; st_addr[0] = 0; st_data[0] = 16'hA0A0;
      st_en[1] = 1; st_addr[1] = 1; st_data[1] = 16'hB1B1;
      st_en[2] = 1; st_addr[2] = 2; st_data[2] = 16'hC2C2;
      step("R2 read");
      idle_writes();
      st_raddr[0] = 0; st_raddr[1] = 1; step("R4 distinct writes");
      st_raddr[0] = 2; st_raddr[1] = 2; step("R4 distinct writes");

      // R5: all ports collide; R3: same-cycle read returns old value.
      for (int w = 0; w < NW; w++) begin
         st_en[w] = 1; st_addr[w] = 3; st_data[w] = 16'h1110 + 16'(w);
      end
      st_raddr[0] = 3; st_raddr[1] = 3; step("R3 old value on write cycle");
      idle_writes(); step("R5 lowest port wins");

      // R7: port 0 disabled but aimed at the same register; port 1 wins.
      st_en[0] = 0; st_addr[0] = 4; st_data[0] = 16'hDEAD;
      st_en[1] = 1; st_addr[1] = 4; st_data[1] = 16'h4141;
      st_en[2] = 1; st_addr[2] = 4; st_data[2] = 16'h4242;
      st_raddr[0] = 4; st_raddr[1] = 0; step("R2 read");
      idle_writes(); step("R7 disabled port ignored");

      // R8: out-of-range collisions write nothing and drop nothing.
      st_en[0] = 1; st_addr[0] = 7; st_data[0] = 16'h7777;
      st_en[1] = 1; st_addr[1] = 7; st_data[1] = 16'h7878;
      st_en[2] = 1; st_addr[2] = 6; st_data[2] = 16'h6666;
      st_raddr[0] = 6; st_raddr[1] = 7; step("R8 out-of-range read");
      idle_writes();
      for (int r = 0; r < NR; r++) begin
         st_raddr[0] = AW'(r); st_raddr[1] = 7;
         step("R8 bank unchanged");
      end

      // R9: idle cycles keep contents.
      for (int i = 0; i < 4; i++) begin
         st_raddr[0] = AW'(i); st_raddr[1] = AW'(i + 1);
         step("R9 hold");
      end

      // Random traffic weighted towards collisions.
      for (int i = 0; i < 3000; i++) begin
         for (int w = 0; w < NW; w++) begin
            st_en[w]   = ($urandom_range(0, 3) != 0);
            st_addr[w] = ($urandom_range(0, 1) != 0) ? AW'($urandom_range(2, 4))
                                                     : AW'($urandom_range(0, 7));
            st_data[w] = DW'($urandom);
         end
         for (int p = 0; p < NRD; p++) st_raddr[p] = AW'($urandom_range(0, 7));
         step("R2 random read");
      end
      idle_writes();
      step("R2 final read");
      @(negedge clk);
      chk("R6 dropped", 32'(wr_dropped), 32'(exp_drop));

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule